// File: doc/BRIEF.md
# Simple-Mode Parallel Port Core

This core gives a processor three byte-wide general purpose I/O ports (A, B and C) behind four byte registers. Each port has an output latch, a per-line output enable and a synchronized input sample. Port C is split into two nibbles, and each nibble has its own direction. Group A covers port A and the upper nibble of C. Group B covers port B and the lower nibble of C. Only simple unstrobed I/O is provided.

The control register accepts two kinds of write, chosen by bit 7 of the written byte. With bit 7 set, the byte is a configuration word that sets the four direction bits and the group mode fields. With bit 7 clear, the byte is a single-bit command that sets or clears one port C latch bit. Register writes take effect on the clock edge where `we_i` is high. Reads are combinational from `addr_i`.

Top module: `ppi_mode0_core`

## Requirements
- R1: After reset, the control readback is 0x9B, every output enable is 0 and every output latch is 0.
- R2: A control write with bit 7 = 1 sets the directions from the written byte: bit 4 sets port A, bit 3 sets port C upper, bit 1 sets port B and bit 0 sets port C lower. A value of 1 means input (output enable 0) and 0 means output (output enable 1). The new enables appear on the clock edge of the write.
- R3: A control write with bit 7 = 1 clears the output latches of ports A, B and C to zero.
- R4: A read of the control register (address 3) returns bit 7 as 1. Bits 6:0 are the bits 6:0 of the last configuration word, or 0x1B after reset.
- R5: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 select port C bit 0 to 7, and bit 0 is written into that latch bit.
- R6: A single-bit command leaves the other port C latch bits, the port A and B latches, all output enables and the control readback unchanged.
- R7: A write to address 0, 1 or 2 loads the written byte into the latch of port A, B or C, and the latch drives that port's output pins.
- R8: A read of address 0, 1 or 2 returns, for each line, the pin value delayed by SYNC_STAGES clocks when the line is an input, and the latch value when it is an output.
- R9: The two port C nibbles follow their own direction bits independently, both for the output enables and for the read path.
- R10: The group mode fields (bits 6:5 and bit 2) are stored and read back. The ports always behave as simple I/O, whatever the mode fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 A, 1 B, 2 C, 3 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
The bench steps through all sixteen direction combinations. For each one it loads a distinct byte into every latch and drives a different byte on every pin. Each line therefore reads back one value as an output and another as an input, and a swapped nibble or an inverted direction shows up in the result. Before each configuration word the latches are filled with non-zero values, so a word that failed to clear them is caught. All sixteen single-bit commands are applied in turn against a tracked model of port C. These separate a wrong select decode or a spill into neighbouring bits from a correct update. A configuration word with non-zero mode fields checks that those fields are stored without changing port behaviour.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned NIB_W  = PORT_W / 2;
  localparam int unsigned SEL_W  = $clog2(PORT_W);

  localparam logic [1:0] ADDR_PA   = 2'd0;
  localparam logic [1:0] ADDR_PB   = 2'd1;
  localparam logic [1:0] ADDR_PC   = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  typedef struct packed {
    logic [1:0] mode_a;
    logic       dir_a;
    logic       dir_cu;
    logic       mode_b;
    logic       dir_b;
    logic       dir_cl;
  } cfg_t;

  localparam cfg_t CFG_RST = '{mode_a: 2'b00, dir_a: 1'b1, dir_cu: 1'b1,
                               mode_b: 1'b0, dir_b: 1'b1, dir_cl: 1'b1};

  // per-line mux: input lines show the pin sample, output lines show the latch
  function automatic logic [PORT_W-1:0] port_view(logic [PORT_W-1:0] pins,
                                                  logic [PORT_W-1:0] latch,
                                                  logic [PORT_W-1:0] in_mask);
    return (pins & in_mask) | (latch & ~in_mask);
  endfunction
endpackage

// File: rtl/ppi_in_sync.sv
module ppi_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       wdata_i,
  output cfg_t             cfg_o,
  output logic             mode_set_o,
  output logic             bit_cmd_o,
  output logic [SEL_W-1:0] bit_sel_o,
  output logic             bit_val_o
);
  cfg_t cfg_q;

  assign mode_set_o = ctrl_we_i &  wdata_i[7];
  assign bit_cmd_o  = ctrl_we_i & ~wdata_i[7];
  assign bit_sel_o  = wdata_i[SEL_W:1];
  assign bit_val_o  = wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= CFG_RST;
    else if (mode_set_o) cfg_q <= cfg_t'(wdata_i[6:0]);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ppi_out_latch.sv
module ppi_out_latch #(
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             bit_we_i,
  input  logic [SEL_W-1:0] bit_sel_i,
  input  logic             bit_val_i,
  output logic [W-1:0]     q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (clr_i)    q <= '0;
    else if (we_i)     q <= wdata_i;
    else if (bit_we_i) q[bit_sel_i] <= bit_val_i;
  end

  assign q_o = q;
endmodule

// File: rtl/ppi_mode0_core.sv
module ppi_mode0_core
  import ppi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [7:0]  pa_i,
  output logic [7:0]  pa_o,
  output logic [7:0]  pa_oe_o,
  input  logic [7:0]  pb_i,
  output logic [7:0]  pb_o,
  output logic [7:0]  pb_oe_o,
  input  logic [7:0]  pc_i,
  output logic [7:0]  pc_o,
  output logic [7:0]  pc_oe_o
);
  localparam int unsigned NPORT = 3;

  cfg_t             cfg;
  logic             mode_set, bit_cmd, bit_val;
  logic [SEL_W-1:0] bit_sel;

  ppi_ctrl_reg u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (we_i && addr_i == ADDR_CTRL),
    .wdata_i    (wdata_i),
    .cfg_o      (cfg),
    .mode_set_o (mode_set),
    .bit_cmd_o  (bit_cmd),
    .bit_sel_o  (bit_sel),
    .bit_val_o  (bit_val)
  );

  logic [PORT_W-1:0] pin_raw  [NPORT];
  logic [PORT_W-1:0] pin_sync [NPORT];
  logic [PORT_W-1:0] latch    [NPORT];
  logic [PORT_W-1:0] in_mask  [NPORT];

  assign pin_raw[0] = pa_i;
  assign pin_raw[1] = pb_i;
  assign pin_raw[2] = pc_i;

  assign in_mask[0] = {PORT_W{cfg.dir_a}};
  assign in_mask[1] = {PORT_W{cfg.dir_b}};
  assign in_mask[2] = {{NIB_W{cfg.dir_cu}}, {NIB_W{cfg.dir_cl}}};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ppi_in_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (pin_raw[p]),
      .q_o    (pin_sync[p])
    );

    ppi_out_latch #(.W(PORT_W), .SEL_W(SEL_W)) u_latch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (mode_set),
      .we_i      (we_i && addr_i == 2'(p)),
      .wdata_i   (wdata_i),
      .bit_we_i  (bit_cmd && p == 2),
      .bit_sel_i (bit_sel),
      .bit_val_i (bit_val),
      .q_o       (latch[p])
    );
  end

  assign pa_o    = latch[0];
  assign pb_o    = latch[1];
  assign pc_o    = latch[2];
  assign pa_oe_o = ~in_mask[0];
  assign pb_oe_o = ~in_mask[1];
  assign pc_oe_o = ~in_mask[2];

  always_comb begin
    unique case (addr_i)
      ADDR_PA:   rdata_o = port_view(pin_sync[0], latch[0], in_mask[0]);
      ADDR_PB:   rdata_o = port_view(pin_sync[1], latch[1], in_mask[1]);
      ADDR_PC:   rdata_o = port_view(pin_sync[2], latch[2], in_mask[2]);
      default:   rdata_o = {1'b1, cfg};
    endcase
  end
endmodule

// File: rtl/ppi_mode0_checker.sv
module ppi_mode0_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       we_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic [7:0] pa_o,
  input logic [7:0] pa_oe_o,
  input logic [7:0] pb_o,
  input logic [7:0] pb_oe_o,
  input logic [7:0] pc_o,
  input logic [7:0] pc_oe_o
);
  logic cfg_wr, bit_wr;
  assign cfg_wr = we_i && addr_i == 2'd3 &&  wdata_i[7];
  assign bit_wr = we_i && addr_i == 2'd3 && !wdata_i[7];

  a_r2_dir_follows_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> pa_oe_o == {8{~$past(wdata_i[4])}} && pb_oe_o == {8{~$past(wdata_i[1])}}
           && pc_oe_o == {{4{~$past(wdata_i[3])}}, {4{~$past(wdata_i[0])}}});

  a_r3_word_clears_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> pa_o == 8'h00 && pb_o == 8'h00 && pc_o == 8'h00);

  a_r5_bit_cmd_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_wr |=> pc_o[$past(wdata_i[3:1])] == $past(wdata_i[0])
           && $countones(pc_o ^ $past(pc_o)) <= 1);

  a_r6_bit_cmd_keeps_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_wr |=> $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o)
           && $stable(pa_o) && $stable(pb_o));

  a_r7_port_a_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> pa_o == $past(wdata_i));

  a_r4_ctrl_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> rdata_o[7]);
endmodule

bind ppi_mode0_core ppi_mode0_checker chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pa_o    (pa_o),
  .pa_oe_o (pa_oe_o),
  .pb_o    (pb_o),
  .pb_oe_o (pb_oe_o),
  .pc_o    (pc_o),
  .pc_oe_o (pc_oe_o)
);

// File: tb/ppi_mode0_core_tb_top.sv
`timescale 1ns/1ps
module ppi_mode0_core_tb_top;
  localparam int unsigned SYNC_STAGES = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
  logic [7:0] pa_o, pa_oe_o, pb_o, pb_oe_o, pc_o, pc_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ppi_mode0_core #(.SYNC_STAGES(SYNC_STAGES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .pa_i(pa_i), .pa_o(pa_o), .pa_oe_o(pa_oe_o),
    .pb_i(pb_i), .pb_o(pb_o), .pb_oe_o(pb_oe_o),
    .pc_i(pc_i), .pc_o(pc_o), .pc_oe_o(pc_oe_o)
  );

  // bench model
  logic [6:0] m_cfg;
  logic [7:0] m_a, m_b, m_c;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
    if (a == 2'd0) m_a = d;
    else if (a == 2'd1) m_b = d;
    else if (a == 2'd2) m_c = d;
    else if (d[7]) begin m_cfg = d[6:0]; m_a = 0; m_b = 0; m_c = 0; end
    else m_c[d[3:1]] = d[0];
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  function automatic logic [7:0] mask_of(logic [6:0] c, int p);
    if (p == 0) return {8{c[4]}};
    if (p == 1) return {8{c[1]}};
    return {{4{c[3]}}, {4{c[0]}}};
  endfunction

  task automatic check_oe(string req);
    chk(req, pa_oe_o, ~mask_of(m_cfg, 0));
    chk(req, pb_oe_o, ~mask_of(m_cfg, 1));
    chk(req, pc_oe_o, ~mask_of(m_cfg, 2));
  endtask

  task automatic check_reads(string req);
    logic [7:0] v;
    rd(2'd0, v); chk(req, v, (pa_i & mask_of(m_cfg, 0)) | (m_a & ~mask_of(m_cfg, 0)));
    rd(2'd1, v); chk(req, v, (pb_i & mask_of(m_cfg, 1)) | (m_b & ~mask_of(m_cfg, 1)));
    rd(2'd2, v); chk(req, v, (pc_i & mask_of(m_cfg, 2)) | (m_c & ~mask_of(m_cfg, 2)));
  endtask

  initial begin
    logic [7:0] v;
    m_cfg = 7'h1B; m_a = 0; m_b = 0; m_c = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd3, v); chk("R1 ctrl", v, 8'h9B);
    chk("R1 oe", pa_oe_o | pb_oe_o | pc_oe_o, 8'h00);
    chk("R1 latch", pa_o | pb_o | pc_o, 8'h00);

    for (int d = 0; d < 16; d++) begin
      logic [7:0] word;
      word = 8'h80 | (8'(d >> 3 & 1) << 4) | (8'(d >> 2 & 1) << 3)
                   | (8'(d >> 1 & 1) << 1) | 8'(d & 1);
      wr(2'd0, 8'hA5 ^ 8'(d)); wr(2'd1, 8'h3C); wr(2'd2, 8'hFF);
      wr(2'd3, word);
      chk("R3 clear A", pa_o, 8'h00); chk("R3 clear B", pb_o, 8'h00);
      chk("R3 clear C", pc_o, 8'h00);
      check_oe("R2 R9 oe");
      rd(2'd3, v); chk("R4 readback", v, word);
      wr(2'd0, 8'(d * 17) ^ 8'h96); wr(2'd1, 8'(d * 29) ^ 8'h4B);
      wr(2'd2, 8'(d * 13) ^ 8'hC3);
      chk("R7 drive A", pa_o, m_a); chk("R7 drive B", pb_o, m_b);
      chk("R7 drive C", pc_o, m_c);
      pa_i = ~m_a; pb_i = 8'(d * 7) ^ 8'h69; pc_i = ~m_c ^ 8'h11;
      repeat (SYNC_STAGES + 1) @(negedge clk);
      check_reads("R8 R9 read");
    end

    // R5 R6 every single-bit command against all-output config
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h81); wr(2'd1, 8'h7E);
    for (int k = 0; k < 16; k++) begin
      wr(2'd3, 8'(k));
      chk("R5 bit cmd", pc_o, m_c);
      chk("R6 A kept", pa_o, 8'h81); chk("R6 B kept", pb_o, 8'h7E);
      check_oe("R6 oe kept");
      rd(2'd3, v); chk("R6 ctrl kept", v, 8'h80);
    end
    for (int k = 15; k >= 0; k--) begin
      wr(2'd3, 8'(k) ^ 8'h01);
      chk("R5 bit cmd rev", pc_o, m_c);
    end
    rd(2'd2, v); chk("R8 C output read", v, m_c);

    // R10 mode fields stored, ports still simple I/O
    wr(2'd3, 8'hE4);
    rd(2'd3, v); chk("R10 readback", v, 8'hE4);
    check_oe("R10 oe");
    wr(2'd1, 8'h5D);
    chk("R10 B drive", pb_o, 8'h5D);
    rd(2'd1, v); chk("R10 B read", v, 8'h5D);
    pa_i = 8'hC6; repeat (SYNC_STAGES + 1) @(negedge clk);
    check_reads("R10 reads");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule